// File: doc/BRIEF.md
# Alarm Match and Interrupt Flag Unit

This block sits beside the time-of-day counter of a real-time clock. At the end of every update cycle the counter pulses `upd_end` and presents the new seconds, minutes and hours. The unit compares these three bytes with the three alarm bytes. When all three agree it latches an alarm flag. The same pulse latches an update-ended flag, and a separate `tick_per` pulse latches a periodic flag.

The three flags are readable as one status byte. Reading it with `stat_rd` returns the flags in that cycle and clears all of them on the next clock edge. An interrupt summary bit, and the `irq_out` line, are high while any flag is set and its enable input is also high.

An alarm byte acts as a wildcard when its top `WILD_BITS` bits are all ones (0xC0 to 0xFF with the defaults). Any other alarm byte must equal the time byte exactly. The hour is always compared as a whole byte, so in 12-hour mode the PM bit in bit 7 takes part in the match. The alarm bytes use the same BCD or binary encoding as the time bytes, so no decoding is needed.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset `stat_data` is 0x00 and `irq_out` is 0.
- R2: When `upd_end` is high and every time byte equals its alarm byte, the alarm flag (status bit 5) reads 1 from the following cycle.
- R3: An alarm byte whose two top bits are both 1 matches any value of its time byte. An alarm byte with only one of those bits set is compared exactly.
- R4: The hour match covers all 8 bits, including the PM bit 7. An alarm hour of 0x02 does not match hour 0x82, and 0x82 does not match 0x02.
- R5: A match while `upd_end` is low sets no flag.
- R6: `upd_end` sets the update flag (status bit 4) and `tick_per` sets the periodic flag (status bit 6), each from the following cycle. Status bits 3:0 always read 0.
- R7: Status bit 7 is 1 exactly when some flag is set and its enable is high. The pairs are: bit 6 with `en_periodic`, bit 5 with `en_alarm`, bit 4 with `en_update`.
- R8: `irq_out` equals status bit 7, so it falls in the cycle after a status read.
- R9: A `stat_rd` cycle shows the current flags on `stat_data`. From the next cycle every flag is clear, so a second read returns 0x00.
- R10: An event in the same cycle as a read is not lost. That read shows the old flags, and the new flag is set afterwards.
- R11: Flags latch whatever the enables are. Raising an enable afterwards raises `irq_out` at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_end | input | 1 | One-cycle pulse at the end of an update; the time inputs are valid in that cycle |
| tick_per | input | 1 | One-cycle periodic event pulse |
| cur_sec | input | FIELD_W | Current seconds |
| cur_min | input | FIELD_W | Current minutes |
| cur_hour | input | FIELD_W | Current hours; bit 7 is PM in 12-hour mode |
| alm_sec | input | FIELD_W | Alarm seconds |
| alm_min | input | FIELD_W | Alarm minutes |
| alm_hour | input | FIELD_W | Alarm hours |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| stat_rd | input | 1 | Status read strobe; clears the flags at the following edge |
| stat_data | output | 8 | Status byte {irq summary, periodic, alarm, update, 4'b0} |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
The properties assume that `upd_end` and `tick_per` are single-cycle pulses. They also assume that the time and alarm bytes are steady in a cycle where `upd_end` is high, so the cycle after the pulse reflects exactly that comparison. The stimulus changes every input at the falling clock edge and holds each strobe for one full cycle. It also keeps the read strobe away from event pulses, except in the one case written to check that an event coinciding with a read is kept. The alarm vectors cover exact matches, wildcards in each field, bytes with only one top bit set, and hours that differ only in the PM bit.

// File: rtl/rtc_alarm_irq_pkg.sv
package rtc_alarm_irq_pkg;
   localparam int STAT_W    = 8;
   localparam int NUM_EVT   = 3;
   localparam int EVT_UPD   = 0;
   localparam int EVT_ALM   = 1;
   localparam int EVT_PER   = 2;
   localparam int FLAG_LSB  = 4;
   localparam int SUM_BIT   = 7;
   localparam int NUM_FIELD = 3;
endpackage

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp #(
   parameter int FIELD_W   = 8,
   parameter int WILD_BITS = 2,
   parameter bit WILD_EN   = 1'b1
) (
   input  logic [FIELD_W-1:0] cur,
   input  logic [FIELD_W-1:0] alm,
   output logic               hit
);
   logic wild;

   generate
      if (WILD_EN) begin : g_wild
         assign wild = &alm[FIELD_W-1 -: WILD_BITS];
      end else begin : g_exact
         assign wild = 1'b0;
      end
   endgenerate

   assign hit = wild | (cur == alm);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int FIELD_W    = 8,
   parameter int NUM_FIELDS = 3,
   parameter int WILD_BITS  = 2,
   parameter bit WILD_EN    = 1'b1
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0] cur_vec,
   input  logic [NUM_FIELDS*FIELD_W-1:0] alm_vec,
   output logic                          all_hit
);
   logic [NUM_FIELDS-1:0] hits;

   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
         rtc_alarm_field_cmp #(
            .FIELD_W  (FIELD_W),
            .WILD_BITS(WILD_BITS),
            .WILD_EN  (WILD_EN)
         ) u_cmp (
            .cur(cur_vec[f*FIELD_W +: FIELD_W]),
            .alm(alm_vec[f*FIELD_W +: FIELD_W]),
            .hit(hits[f])
         );
      end
   endgenerate

   assign all_hit = &hits;
endmodule

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
   parameter int NUM_EVT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_vec,
   input  logic [NUM_EVT-1:0] en_vec,
   input  logic               clr,
   output logic [NUM_EVT-1:0] flags,
   output logic               any_pending
);
   generate
      for (genvar e = 0; e < NUM_EVT; e++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[e] <= 1'b0;
            else if (set_vec[e]) flags[e] <= 1'b1;
            else if (clr)        flags[e] <= 1'b0;
         end
      end
   endgenerate

   assign any_pending = |(flags & en_vec);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_irq_pkg::*;
#(
   parameter int FIELD_W   = 8,
   parameter int WILD_BITS = 2,
   parameter bit WILD_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_end,
   input  logic               tick_per,
   input  logic [FIELD_W-1:0] cur_sec,
   input  logic [FIELD_W-1:0] cur_min,
   input  logic [FIELD_W-1:0] cur_hour,
   input  logic [FIELD_W-1:0] alm_sec,
   input  logic [FIELD_W-1:0] alm_min,
   input  logic [FIELD_W-1:0] alm_hour,
   input  logic               en_alarm,
   input  logic               en_periodic,
   input  logic               en_update,
   input  logic               stat_rd,
   output logic [STAT_W-1:0]  stat_data,
   output logic               irq_out
);
   localparam int VEC_W   = NUM_FIELD * FIELD_W;
   localparam int PAD_W   = FLAG_LSB;

   generate
      if (WILD_BITS < 1 || WILD_BITS > FIELD_W) begin : g_bad_wild
         $error("WILD_BITS must lie between 1 and FIELD_W");
      end
      if (FIELD_W < 4) begin : g_bad_field
         $error("FIELD_W too small for a time byte");
      end
      if (FLAG_LSB + NUM_EVT > SUM_BIT) begin : g_bad_layout
         $error("status layout overlaps the summary bit");
      end
   endgenerate

   logic [VEC_W-1:0]   cur_vec, alm_vec;
   logic               time_hit;
   logic [NUM_EVT-1:0] set_vec, en_vec, flags;
   logic               pending;

   assign cur_vec = {cur_hour, cur_min, cur_sec};
   assign alm_vec = {alm_hour, alm_min, alm_sec};

   rtc_alarm_match #(
      .FIELD_W   (FIELD_W),
      .NUM_FIELDS(NUM_FIELD),
      .WILD_BITS (WILD_BITS),
      .WILD_EN   (WILD_EN)
   ) u_match (
      .cur_vec(cur_vec),
      .alm_vec(alm_vec),
      .all_hit(time_hit)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[EVT_UPD] = upd_end;
      set_vec[EVT_ALM] = upd_end & time_hit;
      set_vec[EVT_PER] = tick_per;
      en_vec           = '0;
      en_vec[EVT_UPD]  = en_update;
      en_vec[EVT_ALM]  = en_alarm;
      en_vec[EVT_PER]  = en_periodic;
   end

   rtc_irq_flag_bank #(
      .NUM_EVT(NUM_EVT)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec),
      .en_vec     (en_vec),
      .clr        (stat_rd),
      .flags      (flags),
      .any_pending(pending)
   );

   assign stat_data = {pending, flags, {PAD_W{1'b0}}};
   assign irq_out   = pending;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
   parameter int FIELD_W   = 8,
   parameter int WILD_BITS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               upd_end,
   input logic               tick_per,
   input logic [FIELD_W-1:0] cur_sec,
   input logic [FIELD_W-1:0] cur_min,
   input logic [FIELD_W-1:0] cur_hour,
   input logic [FIELD_W-1:0] alm_sec,
   input logic [FIELD_W-1:0] alm_min,
   input logic [FIELD_W-1:0] alm_hour,
   input logic               en_alarm,
   input logic               en_periodic,
   input logic               en_update,
   input logic               stat_rd,
   input logic [7:0]         stat_data,
   input logic               irq_out
);
   AST_AF_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_end && cur_sec == alm_sec && cur_min == alm_min && cur_hour == alm_hour)
      |=> stat_data[5]); // R2

   AST_SEC_WILDCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_end && (&alm_sec[FIELD_W-1 -: WILD_BITS]) && cur_min == alm_min && cur_hour == alm_hour)
      |=> stat_data[5]); // R3

   AST_AF_ONLY_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_data[5]) |-> $past(upd_end)); // R5

   AST_UF_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_end |=> stat_data[4]); // R6

   AST_PF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      tick_per |=> stat_data[6]); // R6

   AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stat_data[3:0] == 4'h0); // R6

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((stat_data[6] && en_periodic) || (stat_data[5] && en_alarm)
                   || (stat_data[4] && en_update))); // R7

   AST_IRQ_FROM_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_data[5] && en_alarm) |-> irq_out); // R8

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !upd_end && !tick_per) |=> (stat_data == 8'h00)); // R9
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
   .FIELD_W  (FIELD_W),
   .WILD_BITS(WILD_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_end    (upd_end),
   .tick_per   (tick_per),
   .cur_sec    (cur_sec),
   .cur_min    (cur_min),
   .cur_hour   (cur_hour),
   .alm_sec    (alm_sec),
   .alm_min    (alm_min),
   .alm_hour   (alm_hour),
   .en_alarm   (en_alarm),
   .en_periodic(en_periodic),
   .en_update  (en_update),
   .stat_rd    (stat_rd),
   .stat_data  (stat_data),
   .irq_out    (irq_out)
);

// File: tb/test_rtc_alarm_irq.sv
module test_rtc_alarm_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_end = 1'b0, tick_per = 1'b0, stat_rd = 1'b0;
   logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
   logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
   logic       en_alarm = 1'b0, en_periodic = 1'b0, en_update = 1'b0;
   logic [7:0] stat_data;
   logic       irq_out;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   rtc_alarm_irq i_rtc_alarm_irq (
      .clk(clk), .rst_n(rst_n), .upd_end(upd_end), .tick_per(tick_per),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
      .en_alarm(en_alarm), .en_periodic(en_periodic), .en_update(en_update),
      .stat_rd(stat_rd), .stat_data(stat_data), .irq_out(irq_out)
   );

   // {expected alarm flag, sec, min, hour, alarm sec, alarm min, alarm hour}
   localparam logic [48:0] VEC [12] = '{
      {1'b1, 8'h58, 8'h04, 8'h02, 8'h58, 8'h04, 8'h02},  // R2 exact BCD
      {1'b0, 8'h59, 8'h04, 8'h02, 8'h58, 8'h04, 8'h02},  // R2 seconds differ
      {1'b1, 8'h17, 8'h04, 8'h02, 8'hC0, 8'h04, 8'h02},  // R3 seconds wildcard
      {1'b1, 8'h33, 8'h21, 8'h91, 8'hC0, 8'hC0, 8'hC0},  // R3 all wildcards
      {1'b0, 8'h00, 8'h00, 8'h82, 8'h00, 8'h00, 8'h02},  // R4 PM time, AM alarm
      {1'b0, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h82},  // R4 AM time, PM alarm
      {1'b1, 8'h00, 8'h12, 8'h82, 8'h00, 8'hC0, 8'h82},  // R4 PM on both
      {1'b0, 8'h00, 8'h00, 8'h05, 8'h00, 8'h80, 8'h05},  // R3 one top bit only
      {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40},  // R3 other top bit only
      {1'b1, 8'd59, 8'd59, 8'd23, 8'd59, 8'd59, 8'd23},  // R2 binary encoding
      {1'b1, 8'h37, 8'h00, 8'h8C, 8'hFF, 8'h00, 8'h8C},  // R3 0xFF wildcard
      {1'b0, 8'h00, 8'h01, 8'h03, 8'h00, 8'h00, 8'h03}   // R2 minutes differ
   };

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic pulse_upd();
      @(negedge clk) upd_end = 1'b1;
      @(negedge clk) upd_end = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk) tick_per = 1'b1;
      @(negedge clk) tick_per = 1'b0;
   endtask

   task automatic read_stat(output logic [7:0] val);
      @(negedge clk) stat_rd = 1'b1;
      #1 val = stat_data;
      @(negedge clk) stat_rd = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      check("R1 status after reset", stat_data, 8'h00);
      check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: every update sets UF; AF as listed. Enables are off.
      for (int i = 0; i < 12; i++) begin
         {cur_sec, cur_min, cur_hour, alm_sec, alm_min, alm_hour} = VEC[i][47:0];
         pulse_upd();
         check($sformatf("R2/R3/R4 vector %0d", i), stat_data,
               {2'b00, VEC[i][48], 1'b1, 4'h0});
         read_stat(v);
         check($sformatf("R9 cleared after vector %0d", i), stat_data, 8'h00);
      end

      // R5: a match without the update pulse sets nothing
      {cur_sec, cur_min, cur_hour, alm_sec, alm_min, alm_hour} = VEC[0][47:0];
      repeat (4) @(negedge clk);
      check("R5 no update no flag", stat_data, 8'h00);

      // R6 periodic flag, then R9 double read
      pulse_tick();
      read_stat(v);
      check("R6 periodic flag read", v, 8'h40);
      read_stat(v);
      check("R9 second read is zero", v, 8'h00);

      // R7/R8 with update enable
      en_update = 1'b1;
      cur_sec = 8'h01;
      pulse_upd();
      check("R7 summary with update enable", stat_data, 8'h90);
      check("R8 irq high", {7'd0, irq_out}, 8'h01);
      read_stat(v);
      check("R9 read value", v, 8'h90);
      check("R8 irq low after read", {7'd0, irq_out}, 8'h00);
      en_update = 1'b0;

      // R11: flags latch without enable, enable raises irq at once
      cur_sec = 8'h58;
      pulse_upd();
      check("R11 flags without enable", stat_data, 8'h30);
      check("R11 irq stays low", {7'd0, irq_out}, 8'h00);
      en_periodic = 1'b1;
      #1 check("R7 enable of clear flag gives no irq", {7'd0, irq_out}, 8'h00);
      en_periodic = 1'b0;
      en_alarm = 1'b1;
      #1 check("R11 irq rises on enable", {7'd0, irq_out}, 8'h01);
      check("R7 summary on alarm enable", stat_data, 8'hB0);
      read_stat(v);
      en_alarm = 1'b0;

      // R10: event in the same cycle as a read
      @(negedge clk) begin stat_rd = 1'b1; tick_per = 1'b1; end
      #1 v = stat_data;
      @(negedge clk) begin stat_rd = 1'b0; tick_per = 1'b0; end
      check("R10 read shows old flags", v, 8'h00);
      check("R10 coinciding event kept", stat_data, 8'h40);
      read_stat(v);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule